// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software reach the management registers of external Ethernet PHYs over a two-wire serial management bus. Software uses a small 32-bit register bus. It loads the target PHY and register numbers, and the outgoing data for a write. It then fires a command and polls a busy flag until the serial frame has finished. For a read, the 16-bit value returned by the PHY is then waiting in its own result register.

The block derives the management clock (MDC) from the system clock through a programmable divider. It drives the data line through separate output and output-enable signals, and it samples the line through a separate input. The pad and tristate cell lie outside the block.

A state machine paces each frame. It starts in ST_IDLE and moves to ST_PREAMBLE when a start command is accepted. It moves to ST_HEADER after the 32nd preamble bit, to ST_TURN after the 14 header bits (start, opcode, PHY address, register address) and to ST_DATA after the two turnaround bits. It returns to ST_IDLE after the 16th data bit. Each bit ends on an MDC falling edge. Bus reads return data registered one cycle after the read strobe.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the config word at offset 0x40 reads 0x000150FF. The command word at 0x50 and the result word at 0x4C read 0. MDC and the output enable are low.
- R2: Writes and reads use five word offsets: 0x40 config (all 32 bits read back as written), 0x44 target (PHY number in bits [12:8], register number in bits [4:0], other bits read 0), 0x48 outgoing data (bits [15:0], upper bits read 0), 0x4C result and 0x50 command. Read data appears on the cycle after the read strobe.
- R3: A write to 0x50 with bit 8 set, made while idle, starts a frame. Bit 0 of that write selects the operation: 0 is read and 1 is write. From the next cycle, bit 16 of 0x50 (busy) reads 1 and bit 0 reads back the operation.
- R4: While a frame runs, MDC begins low and toggles every div+1 system clocks, where div is config bits [7:0]. This gives a period of 2*(div+1) clocks. MDC stays low while idle.
- R5: Every frame sends, with the line driven and MSB first: 32 ones, then 01, then the operation code (10 for read, 01 for write), the 5-bit PHY number and the 5-bit register number.
- R6: A write frame continues with the turnaround 10, then the 16 outgoing data bits MSB first, with the output enable held high for all 64 bits.
- R7: A read frame drops the output enable for the 2 turnaround bits and the 16 data bits. It samples the input on each MDC rising edge of the data phase, MSB first. At the end of the frame it places the 16-bit value in 0x4C bits [15:0].
- R8: The data output and the output enable change only when MDC falls, and never while MDC is high.
- R9: Busy stays set for exactly 128*(div+1) system clocks and clears together with the final MDC falling edge.
- R10: A start command written while busy is ignored. The running frame continues unchanged and the operation bit in 0x50 keeps its value.
- R11: Only five bits of each address field are stored and sent. Target bits outside [12:8] and [4:0] are discarded and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The assertions assume that software leaves the config divider untouched while busy is set. The cycle timing they check depends on that. The stimulus writes the config word only between frames, after polling shows busy clear.

The assertions also assume the bus strobes are single-cycle and never both active at once. The bench tasks drive exactly one strobe for one cycle on each access.

The bench PHY drives the input line only during the read data phase and otherwise leaves it at the idle-high level. This matches the one-to-one timing the read capture relies on.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    // Word offsets decoded on the register bus
    localparam logic [7:0] OFS_CFG  = 8'h40;
    localparam logic [7:0] OFS_ADDR = 8'h44;
    localparam logic [7:0] OFS_WDAT = 8'h48;
    localparam logic [7:0] OFS_RDAT = 8'h4C;
    localparam logic [7:0] OFS_CMD  = 8'h50;

    localparam logic [31:0] CFG_RESET     = 32'h0001_50FF;
    localparam int          CMD_START_BIT = 8;
    localparam int          CMD_BUSY_BIT  = 16;
    localparam int          PHY_LSB       = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } seq_state_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             hit;

    assign hit = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc       = mdc_q;
    assign rise_tick = hit && !mdc_q;
    assign fall_tick = hit &&  mdc_q;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int FLD_W    = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_write,
    input  logic [FLD_W-1:0]  phy,
    input  logic [FLD_W-1:0]  regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              mdo,
    output logic              mdoe
);

    localparam int HDR_BITS = 4 + 2 * FLD_W;
    localparam int TA_BITS  = 2;
    localparam int SH_W     = HDR_BITS + TA_BITS + DATA_W;
    localparam int MAXP     = (PRE_BITS > DATA_W) ? PRE_BITS : DATA_W;
    localparam int CNT_W    = $clog2(MAXP);

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SH_W-1:0]   tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              wr_q;
    int                phase_len;
    logic              last;
    logic              accept;

    assign accept = start && (state_q == ST_IDLE);

    always_comb begin
        phase_len = 1;
        unique case (state_q)
            ST_IDLE:     phase_len = 1;
            ST_PREAMBLE: phase_len = PRE_BITS;
            ST_HEADER:   phase_len = HDR_BITS;
            ST_TURN:     phase_len = TA_BITS;
            ST_DATA:     phase_len = DATA_W;
        endcase
    end

    assign last = fall_tick && (int'(bit_cnt) == phase_len - 1);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (last)   state_d = ST_HEADER;
            ST_HEADER:   if (last)   state_d = ST_TURN;
            ST_TURN:     if (last)   state_d = ST_DATA;
            ST_DATA:     if (last)   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath: bit counter, transmit and receive shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            bit_cnt <= '0;
            wr_q    <= op_write;
            tx_sh   <= {2'b01,
                        (op_write ? 2'b01 : 2'b10),
                        phy, regad,
                        (op_write ? 2'b10 : 2'b00),
                        (op_write ? wdata : {DATA_W{1'b0}})};
        end else begin
            if (fall_tick) begin
                bit_cnt <= last ? '0 : bit_cnt + 1'b1;
                if (state_q != ST_PREAMBLE && state_q != ST_IDLE)
                    tx_sh <= {tx_sh[SH_W-2:0], 1'b0};
            end
            if (rise_tick && state_q == ST_DATA && !wr_q)
                rx_sh <= {rx_sh[DATA_W-2:0], mdi};
        end
    end

    // line outputs
    always_comb begin
        mdo  = 1'b1;
        mdoe = 1'b0;
        unique case (state_q)
            ST_IDLE:     begin mdo = 1'b1;         mdoe = 1'b0; end
            ST_PREAMBLE: begin mdo = 1'b1;         mdoe = 1'b1; end
            ST_HEADER:   begin mdo = tx_sh[SH_W-1]; mdoe = 1'b1; end
            ST_TURN:     begin mdo = tx_sh[SH_W-1]; mdoe = wr_q; end
            ST_DATA:     begin mdo = tx_sh[SH_W-1]; mdoe = wr_q; end
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DATA) && last;
    assign rx_word = rx_sh;

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int FLD_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_word,
    output logic              start,
    output logic              op_write,
    output logic [DIV_W-1:0]  div,
    output logic [FLD_W-1:0]  phy,
    output logic [FLD_W-1:0]  regad,
    output logic [DATA_W-1:0] wdata
);

    logic [31:0]       cfg_q;
    logic [FLD_W-1:0]  phy_q, reg_q;
    logic [DATA_W-1:0] wdat_q, rdat_q;
    logic              op_q;
    logic [31:0]       rd_mux;

    assign start = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[CMD_START_BIT] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RESET;
            phy_q  <= '0;
            reg_q  <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            op_q   <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == OFS_CFG)  cfg_q <= bus_wdata;
            if (bus_wr && bus_addr == OFS_ADDR) begin
                phy_q <= bus_wdata[PHY_LSB +: FLD_W];
                reg_q <= bus_wdata[FLD_W-1:0];
            end
            if (bus_wr && bus_addr == OFS_WDAT) wdat_q <= bus_wdata[DATA_W-1:0];
            if (start)                          op_q   <= bus_wdata[0];
            if (done && !op_q)                  rdat_q <= rx_word;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_CFG:  rd_mux = cfg_q;
            OFS_ADDR: begin
                rd_mux[PHY_LSB +: FLD_W] = phy_q;
                rd_mux[FLD_W-1:0]        = reg_q;
            end
            OFS_WDAT: rd_mux[DATA_W-1:0] = wdat_q;
            OFS_RDAT: rd_mux[DATA_W-1:0] = rdat_q;
            OFS_CMD:  begin
                rd_mux[CMD_BUSY_BIT] = busy;
                rd_mux[0]            = op_q;
            end
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign op_write = bus_wdata[0];
    assign div      = cfg_q[DIV_W-1:0];
    assign phy      = phy_q;
    assign regad    = reg_q;
    assign wdata    = wdat_q;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
    parameter int DIV_W    = 8,
    parameter int FLD_W    = 5,
    parameter int DATA_W   = 16,
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic              start, op_write;
    logic [DIV_W-1:0]  cfg_div;
    logic [FLD_W-1:0]  phy, regad;
    logic [DATA_W-1:0] wdata, rx_word;
    logic              seq_busy, seq_done;
    logic              rise_tick, fall_tick;

    mdio_csr #(.DIV_W(DIV_W), .FLD_W(FLD_W), .DATA_W(DATA_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .busy      (seq_busy),
        .done      (seq_done),
        .rx_word   (rx_word),
        .start     (start),
        .op_write  (op_write),
        .div       (cfg_div),
        .phy       (phy),
        .regad     (regad),
        .wdata     (wdata)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (seq_busy),
        .div       (cfg_div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq #(.PRE_BITS(PRE_BITS), .FLD_W(FLD_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_write  (op_write),
        .phy       (phy),
        .regad     (regad),
        .wdata     (wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdi       (mdio_i),
        .busy      (seq_busy),
        .done      (seq_done),
        .rx_word   (rx_word),
        .mdo       (mdio_o),
        .mdoe      (mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy
);

    AST_IDLE_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)) else $error("idle line not quiet"); // R4

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && bus_addr == 8'h50 && bus_wdata[8]) |=> busy)
        else $error("start not taken"); // R3

    AST_DATA_HELD_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)))
        else $error("line moved while MDC high"); // R8

    AST_BUSY_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(mdc)) else $error("busy cleared off MDC fall"); // R9

    AST_FRAME_OPENS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_o && !mdc))
        else $error("frame did not open with driven one"); // R5

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mdc && bus_wr && bus_addr == 8'h50) |=> (busy && $stable(mdio_o)))
        else $error("start during busy disturbed frame"); // R10

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (seq_busy)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int errors = 0;
    bit run_chk = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mdio_mgmt_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- reference model ----------------
    bit          m_active = 1'b0;
    int          m_c = 0;
    int          m_d = 256;
    bit          m_wr = 1'b0;
    int          m_reg = 0;
    logic [15:0] m_wd = 16'h0;
    logic [63:0] m_frame = 64'h0;
    logic [4:0]  sh_phy = 5'h0, sh_reg = 5'h0;
    logic [15:0] sh_wd = 16'h0;
    logic [15:0] phy_regs [32];

    initial for (int i = 0; i < 32; i++) phy_regs[i] = 16'hC35A ^ 16'(i * 16'h0111);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 1'b0;
            m_d      = 256;
        end else begin
            if (m_active) begin
                m_c++;
                if (m_c == 128 * m_d) begin
                    m_active = 1'b0;
                    if (m_wr) phy_regs[m_reg] = m_wd;
                end
            end else if (bus_wr && bus_addr == 8'h50 && bus_wdata[8]) begin
                m_active = 1'b1;
                m_c      = 0;
                m_wr     = bus_wdata[0];
                m_reg    = int'(sh_reg);
                m_wd     = sh_wd;
                m_frame  = {32'hFFFF_FFFF, 2'b01, (m_wr ? 2'b01 : 2'b10), sh_phy, sh_reg,
                            (m_wr ? 2'b10 : 2'b00), (m_wr ? sh_wd : phy_regs[sh_reg])};
            end
            if (bus_wr && bus_addr == 8'h40) m_d = int'(bus_wdata[7:0]) + 1;
            if (bus_wr && bus_addr == 8'h44) begin
                sh_phy = bus_wdata[12:8];
                sh_reg = bus_wdata[4:0];
            end
            if (bus_wr && bus_addr == 8'h48) sh_wd = bus_wdata[15:0];
        end
    end

    // PHY: drives register bits during the read data phase, idle-high otherwise
    int m_b;
    assign m_b    = m_c / (2 * m_d);
    assign mdio_i = (m_active && !m_wr && m_b >= 48) ? m_frame[63 - m_b] : 1'b1;

    function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (run_chk) begin
            logic e_mdc, e_oe;
            string tg;
            e_mdc = m_active ? ((m_c / m_d) % 2 == 1) : 1'b0;
            e_oe  = m_active && (m_b < 46 || m_wr);
            chk("R4 mdc", {31'b0, mdc}, {31'b0, e_mdc});
            tg = (!m_active || m_b < 46) ? "R5 line" : (m_wr ? "R6 line" : "R7 line");
            chk(tg, {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe) chk(tg, {31'b0, mdio_o}, {31'b0, m_frame[63 - m_b]});
        end
    end

    // ---------------- bus tasks (called at a negedge) ----------------
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // wait to the last busy cycle, then check the busy edge exactly (R9)
    task automatic wait_end(input logic op);
        logic [31:0] v;
        while (m_active && m_c != 128 * m_d - 1) @(negedge clk);
        bus_read(8'h50, v);
        chk("R9 busy last cycle", v, {15'b0, 1'b1, 15'b0, op});
        bus_read(8'h50, v);
        chk("R9 busy cleared", v, {31'b0, op});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_chk = 1'b1;

        // R1 reset state
        chk("R1 mdc", {31'b0, mdc}, 32'h0);
        chk("R1 oe", {31'b0, mdio_oe}, 32'h0);
        bus_read(8'h40, v); chk("R1 config", v, 32'h0001_50FF);
        bus_read(8'h50, v); chk("R1 command", v, 32'h0);
        bus_read(8'h4C, v); chk("R1 result", v, 32'h0);

        // R2 register map, R11 field masking
        bus_write(8'h40, 32'hABC0_0002);
        bus_read(8'h40, v); chk("R2 config", v, 32'hABC0_0002);
        bus_write(8'h44, 32'hFFFF_FFFF);
        bus_read(8'h44, v); chk("R11 target mask", v, 32'h0000_1F1F);
        bus_write(8'h44, 32'h0000_0503);
        bus_read(8'h44, v); chk("R2 target", v, 32'h0000_0503);
        bus_write(8'h48, 32'h1234_BEEF);
        bus_read(8'h48, v); chk("R2 outgoing", v, 32'h0000_BEEF);

        // R3 write frame, R10 start while busy ignored
        bus_write(8'h50, 32'h0000_0101);
        bus_read(8'h50, v); chk("R3 busy+op write", v, 32'h0001_0001);
        repeat (50) @(negedge clk);
        bus_write(8'h50, 32'h0000_0100);
        bus_read(8'h50, v); chk("R10 op kept", v, 32'h0001_0001);
        wait_end(1'b1);

        // R7 read back the register just written
        bus_write(8'h50, 32'h0000_0100);
        bus_read(8'h50, v); chk("R3 busy+op read", v, 32'h0001_0000);
        wait_end(1'b0);
        bus_read(8'h4C, v); chk("R7 result", v, 32'h0000_BEEF);

        // R4 fastest divider, R7 read of an untouched register
        bus_write(8'h40, 32'h0000_0000);
        bus_write(8'h44, 32'h0000_1A11);
        bus_write(8'h50, 32'h0000_0100);
        wait_end(1'b0);
        bus_read(8'h4C, v);
        chk("R7 result fresh", v, {16'h0, 16'hC35A ^ 16'(17 * 16'h0111)});

        // R11 upper address bits ignored in the frame
        bus_write(8'h44, 32'hFFFF_E7E2);
        bus_write(8'h48, 32'h0000_5A5A);
        bus_write(8'h50, 32'h0000_0101);
        wait_end(1'b1);
        bus_write(8'h50, 32'h0000_0100);
        wait_end(1'b0);
        bus_read(8'h4C, v); chk("R11 masked target roundtrip", v, 32'h0000_5A5A);

        // R9 full-length frame at reset divider
        bus_write(8'h40, 32'h0001_50FF);
        bus_write(8'h48, 32'h0000_8001);
        bus_write(8'h50, 32'h0000_0101);
        wait_end(1'b1);

        run_chk = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule